// File: doc/BRIEF.md
# Dual-Entry Color Palette Expander

This block holds a 256-color lookup palette for a display pipeline. The palette lives in 128 bus-writable 32-bit words. Each word carries two 16-bit color entries, and each entry packs three 5-bit channels and one intensity flag. A bus write keeps the raw word for later readback. In the same edge it also converts both entries it carries into 24-bit colors with 8 bits per channel. Those converted colors go into a second store, which the pixel path reads through a dedicated lookup port addressed by an 8-bit color index.

Software sees exactly the value it wrote. The pixel path never pays for the conversion, because that work is done once per write and not once per pixel. Bus address decoding outside the palette window, and the pixel pipeline itself, belong to the surrounding logic.

Top module: `pal_expand`

## Requirements
- R1: After reset every raw word reads as 0 and every lookup index returns color 0.
- R2: A bus write with `wr_en` high stores `wr_data` at word `wr_addr`. `rd_data` shows the exact 32-bit value of word `rd_addr` one clock edge after `rd_addr` is presented.
- R3: Lookup index `i` selects word `i[7:1]`. When `i[0]` is 0 the entry is bits [15:0] of that word; when `i[0]` is 1 it is bits [31:16].
- R4: Within a 16-bit entry, bits [4:0] are red, [9:5] are green and [14:10] are blue. On `lk_color`, red appears at [23:16], green at [15:8] and blue at [7:0].
- R5: Each 5-bit channel becomes an 8-bit channel equal to the 5-bit value shifted left by 3, so the three low bits of every output channel are 0.
- R6: Bit 15 of each entry (the intensity flag) has no effect on the looked-up color.
- R7: `lk_color` shows the color of `lk_idx` one clock edge after `lk_idx` is presented. A word written at one edge is visible to a lookup presented in the next cycle.
- R8: When a write and a read or lookup of the same location fall in the same cycle, the read or lookup returns the value held before that write.
- R9: A write to word n changes only entries 2n and 2n+1. Every other word and entry keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 7 | Word index of the write |
| wr_data | input | 32 | Raw word to store, two packed entries |
| rd_addr | input | 7 | Word index for bus readback |
| rd_data | output | 32 | Raw word, registered |
| lk_idx | input | 8 | Color index for the pixel path |
| lk_color | output | 24 | Expanded color {red, green, blue}, registered |

## Verification
Both results are due one edge after their address is presented. A write becomes visible to a read or lookup presented in the following cycle, and a same-cycle access to the location being written still returns the old value. The scoreboard tags every expected readback and color with the cycle in which it falls due. The monitor pops and compares an item only in that cycle, sampling at the falling edge, so a result that arrives one cycle early or late is reported. The expected values come from a word-level model in the bench that is updated after the expectation for the same cycle is taken, which is what covers the collision case.

// File: rtl/pal_pkg.sv
package pal_pkg;
   // three color channels per entry
   localparam int NUM_CH = 3;

   // output slot of a channel, counted from the least significant end
   typedef enum int {
      SLOT_BLUE  = 0,
      SLOT_GREEN = 1,
      SLOT_RED   = 2
   } out_slot_e;

   // input field of an entry feeding a given output slot (red is field 0)
   function automatic int src_field(input int slot);
      return NUM_CH - 1 - slot;
   endfunction
endpackage

// File: rtl/pal_chan_expand.sv
module pal_chan_expand #(
   parameter int IN_W  = 5,
   parameter int OUT_W = 8
) (
   input  logic [IN_W-1:0]  ch_in,
   output logic [OUT_W-1:0] ch_out
);
   if (OUT_W < IN_W) begin : g_bad_width
      $error("pal_chan_expand: OUT_W must not be below IN_W");
   end

   if (OUT_W == IN_W) begin : g_pass
      assign ch_out = ch_in;
   end else begin : g_pad
      localparam int PAD_W = OUT_W - IN_W;
      assign ch_out = {ch_in, {PAD_W{1'b0}}};
   end
endmodule

// File: rtl/pal_entry_expand.sv
module pal_entry_expand #(
   parameter int CH_W  = 5,
   parameter int OUT_W = 8,
   localparam int IN_W    = pal_pkg::NUM_CH * CH_W,
   localparam int COLOR_W = pal_pkg::NUM_CH * OUT_W
) (
   input  logic [IN_W-1:0]    entry,
   output logic [COLOR_W-1:0] color
);
   for (genvar s = 0; s < pal_pkg::NUM_CH; s++) begin : g_slot
      localparam int SRC = pal_pkg::src_field(s);
      pal_chan_expand #(.IN_W(CH_W), .OUT_W(OUT_W)) u_chan (
         .ch_in  (entry[SRC*CH_W +: CH_W]),
         .ch_out (color[s*OUT_W +: OUT_W])
      );
   end
endmodule

// File: rtl/pal_raw_store.sv
module pal_raw_store #(
   parameter int NUM_WORDS = 128,
   parameter int WORD_W    = 32,
   localparam int ADDR_W   = $clog2(NUM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] mem [NUM_WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
         rd_data <= '0;
      end else begin
         rd_data <= mem[rd_addr];
         if (wr_en) mem[wr_addr] <= wr_data;
      end
   end
endmodule

// File: rtl/pal_exp_store.sv
module pal_exp_store #(
   parameter int NUM_WORDS = 128,
   parameter int COLOR_W   = 24,
   localparam int ADDR_W   = $clog2(NUM_WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [1:0][COLOR_W-1:0] wr_color,
   input  logic [ADDR_W:0]         lk_idx,
   output logic [COLOR_W-1:0]      lk_color
);
   logic [COLOR_W-1:0] half_q [2];
   logic               half_sel;

   for (genvar h = 0; h < 2; h++) begin : g_bank
      logic [COLOR_W-1:0] mem [NUM_WORDS];
      logic [COLOR_W-1:0] q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
            q <= '0;
         end else begin
            q <= mem[lk_idx[ADDR_W:1]];
            if (wr_en) mem[wr_addr] <= wr_color[h];
         end
      end

      assign half_q[h] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) half_sel <= 1'b0;
      else        half_sel <= lk_idx[0];
   end

   assign lk_color = half_sel ? half_q[1] : half_q[0];
endmodule

// File: rtl/pal_expand.sv
module pal_expand #(
   parameter int NUM_WORDS = 128,
   parameter int WORD_W    = 32,
   parameter int CH_W      = 5,
   parameter int OUT_W     = 8,
   localparam int ENTRY_W  = WORD_W / 2,
   localparam int ADDR_W   = $clog2(NUM_WORDS),
   localparam int IDX_W    = ADDR_W + 1,
   localparam int FIELD_W  = pal_pkg::NUM_CH * CH_W,
   localparam int COLOR_W  = pal_pkg::NUM_CH * OUT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [WORD_W-1:0]  rd_data,
   input  logic [IDX_W-1:0]   lk_idx,
   output logic [COLOR_W-1:0] lk_color
);
   if (WORD_W % 2 != 0) begin : g_bad_word
      $error("pal_expand: WORD_W must hold two entries");
   end
   if (FIELD_W > ENTRY_W) begin : g_bad_entry
      $error("pal_expand: channels do not fit in an entry");
   end
   if ((1 << ADDR_W) != NUM_WORDS) begin : g_bad_depth
      $error("pal_expand: NUM_WORDS must be a power of two");
   end

   logic [1:0][COLOR_W-1:0] pair_color;

   for (genvar h = 0; h < 2; h++) begin : g_half
      pal_entry_expand #(.CH_W(CH_W), .OUT_W(OUT_W)) u_conv (
         .entry (wr_data[h*ENTRY_W +: FIELD_W]),
         .color (pair_color[h])
      );
   end

   pal_raw_store #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_raw (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   pal_exp_store #(.NUM_WORDS(NUM_WORDS), .COLOR_W(COLOR_W)) u_exp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_color (pair_color),
      .lk_idx   (lk_idx),
      .lk_color (lk_color)
   );
endmodule

// File: rtl/pal_expand_chk.sv
module pal_expand_chk #(
   parameter int NUM_WORDS = 128,
   parameter int WORD_W    = 32,
   parameter int CH_W      = 5,
   parameter int OUT_W     = 8,
   localparam int ENTRY_W  = WORD_W / 2,
   localparam int ADDR_W   = $clog2(NUM_WORDS),
   localparam int IDX_W    = ADDR_W + 1,
   localparam int COLOR_W  = 3 * OUT_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [WORD_W-1:0]  wr_data,
   input logic [ADDR_W-1:0]  rd_addr,
   input logic [WORD_W-1:0]  rd_data,
   input logic [IDX_W-1:0]   lk_idx,
   input logic [COLOR_W-1:0] lk_color
);
   function automatic logic [COLOR_W-1:0] ref_color(input logic [ENTRY_W-1:0] e);
      logic [COLOR_W-1:0] c;
      c = '0;
      for (int s = 0; s < 3; s++)
         c[s*OUT_W +: OUT_W] = OUT_W'(e[(2-s)*CH_W +: CH_W]) << (OUT_W - CH_W);
      return c;
   endfunction

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_data == '0 && lk_color == '0));

   // R2
   readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en ##1 (!wr_en && rd_addr == $past(wr_addr))
      |=> rd_data == $past(wr_data, 2));

   // R3
   lookup_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en ##1 (!wr_en && lk_idx[IDX_W-1:1] == $past(wr_addr))
      |=> lk_color == ($past(lk_idx[0]) ? ref_color($past(wr_data[WORD_W-1:ENTRY_W], 2))
                                        : ref_color($past(wr_data[ENTRY_W-1:0], 2))));

   if (OUT_W > CH_W) begin : g_low
      for (genvar s = 0; s < 3; s++) begin : g_slot
         // R5
         low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lk_color[s*OUT_W +: (OUT_W - CH_W)] == '0);
      end
   end
endmodule

bind pal_expand pal_expand_chk #(
   .NUM_WORDS (NUM_WORDS),
   .WORD_W    (WORD_W),
   .CH_W      (CH_W),
   .OUT_W     (OUT_W)
) u_chk (.*);

// File: tb/pal_expand_test.sv
`timescale 1ns/1ps
module pal_expand_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [6:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [6:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [7:0]  lk_idx = '0;
   logic [23:0] lk_color;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      int          due;
      bit          is_rd;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   logic [31:0] model [128];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pal_expand uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .lk_idx(lk_idx), .lk_color(lk_color)
   );

   function automatic logic [23:0] color_of(input logic [15:0] e);
      return {e[4:0], 3'b000, e[9:5], 3'b000, e[14:10], 3'b000};
   endfunction

   function automatic logic [23:0] model_color(input logic [7:0] i);
      logic [31:0] w;
      w = model[i[7:1]];
      return i[0] ? color_of(w[31:16]) : color_of(w[15:0]);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // one bus/lookup cycle; empty tag means that result is not checked
   task automatic step(input bit we, input logic [6:0] wa, input logic [31:0] wd,
                       input logic [6:0] ra, input logic [7:0] li,
                       input string trd, input string tlk);
      item_t it;
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; lk_idx = li;
      if (trd != "") begin
         it.due = cyc + 1; it.is_rd = 1'b1; it.exp = model[ra]; it.tag = trd;
         sb.push_back(it);
      end
      if (tlk != "") begin
         it.due = cyc + 1; it.is_rd = 1'b0; it.exp = {8'h00, model_color(li)}; it.tag = tlk;
         sb.push_back(it);
      end
      if (we) model[wa] = wd;
   endtask

   task automatic wr(input logic [6:0] wa, input logic [31:0] wd);
      step(1'b1, wa, wd, 7'd0, 8'd0, "", "");
   endtask

   // monitor: compare each item in the cycle it falls due
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         item_t it;
         it = sb.pop_front();
         if (it.due != cyc) begin
            check({it.tag, " stale item"}, 32'(it.due), 32'(cyc));
         end else if (it.is_rd) begin
            check({it.tag, " rd_data"}, rd_data, it.exp);
         end else begin
            check({it.tag, " lk_color"}, {8'h00, lk_color}, it.exp);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 128; i++) model[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset rd_data", rd_data, 32'h0);
      check("R1 reset lk_color", {8'h00, lk_color}, 32'h0);
      rst_n = 1'b1;

      // R1: untouched locations read zero
      step(1'b0, 7'd0, 32'h0, 7'd0, 8'd0, "R1", "R1");
      step(1'b0, 7'd0, 32'h0, 7'd127, 8'd255, "R1", "R1");
      step(1'b0, 7'd0, 32'h0, 7'd64, 8'd129, "R1", "R1");

      // R4 channel placement, R6 intensity, R5 expansion
      wr(7'd1, 32'h03E0_001F);
      wr(7'd2, 32'hFC00_7C00);
      wr(7'd3, 32'h8000_0000);
      wr(7'd4, 32'h0421_8421);
      wr(7'd6, 32'h4631_2A95);
      step(1'b0, 7'd0, 32'h0, 7'd1, 8'd2, "R2", "R4");
      step(1'b0, 7'd0, 32'h0, 7'd2, 8'd3, "R2", "R4");
      step(1'b0, 7'd0, 32'h0, 7'd3, 8'd4, "R2", "R4");
      step(1'b0, 7'd0, 32'h0, 7'd4, 8'd5, "R2", "R6");
      step(1'b0, 7'd0, 32'h0, 7'd6, 8'd7, "R2", "R6");
      step(1'b0, 7'd0, 32'h0, 7'd6, 8'd8, "R2", "R6");
      step(1'b0, 7'd0, 32'h0, 7'd6, 8'd9, "R2", "R6");
      step(1'b0, 7'd0, 32'h0, 7'd6, 8'd12, "R2", "R5");
      step(1'b0, 7'd0, 32'h0, 7'd6, 8'd13, "R2", "R5");
      // R3: index 6 is word 3 low half (zero), word 4 upper half is checked above
      step(1'b0, 7'd0, 32'h0, 7'd3, 8'd6, "R3", "R3");

      // R8: same-cycle write and access return the previous value
      step(1'b1, 7'd1, 32'h1234_5678, 7'd1, 8'd3, "R8", "R8");
      step(1'b1, 7'd2, 32'h0F0F_7777, 7'd2, 8'd4, "R8", "R8");
      step(1'b0, 7'd0, 32'h0, 7'd1, 8'd2, "R2", "R3");
      step(1'b0, 7'd0, 32'h0, 7'd2, 8'd5, "R2", "R3");

      // R7: write then access in the very next cycle; back-to-back lookups
      step(1'b1, 7'd10, 32'h5A5A_A5A5, 7'd0, 8'd0, "", "");
      step(1'b0, 7'd0, 32'h0, 7'd10, 8'd20, "R7", "R7");
      step(1'b0, 7'd0, 32'h0, 7'd10, 8'd21, "R7", "R7");
      step(1'b0, 7'd0, 32'h0, 7'd1, 8'd3, "R7", "R7");
      step(1'b0, 7'd0, 32'h0, 7'd6, 8'd20, "R7", "R7");

      // R9: fill all words, then every word and entry must match
      for (int i = 0; i < 128; i++)
         wr(7'(i), (32'(i) * 32'h9E37_79B1) ^ 32'h1357_9BDF);
      wr(7'd77, 32'hFFFF_FFFF);
      for (int i = 0; i < 128; i++)
         step(1'b0, 7'd0, 32'h0, 7'(i), 8'(2 * i), "R9", "R9");
      for (int i = 0; i < 128; i++)
         step(1'b0, 7'd0, 32'h0, 7'(127 - i), 8'(2 * i + 1), "R2", "R3");

      step(1'b0, 7'd0, 32'h0, 7'd0, 8'd0, "", "");
      repeat (3) @(negedge clk);
      check("scoreboard drained", 32'(sb.size()), 32'h0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule